// File: doc/BRIEF.md
# Sequential 16-bit Register-Transfer Processor Core

This core runs a small program held in an external word-addressed memory of 4096 sixteen-bit words. Each instruction is handled in a fixed frame of eight clock cycles. The first five cycles fetch and decode the word at the program counter. The last three cycles carry out the operation. Every register transfer passes over one shared internal bus. Memory is reached only through a 12-bit address register and a 16-bit buffer register.

An instruction word carries a 4-bit opcode in bits 15..12 and a 12-bit operand in bits 11..0. The operand is either a constant or an offset that is added to a pointer register. Five operations exist: stop, load a constant into the general register, load the pointer register, load the general register from memory, and store the general register to memory. The effective address of a memory operation is pointer plus offset. Software drives the core by placing a program at address 0, releasing reset and waiting for the halted output.

Top module: `seqcore_top`

## Requirements
- R1: While reset (active-low rstN) is held, halted is 0, memWe is 0 and memAddr is 0. After release, the first instruction is fetched from address 0.
- R2: Instruction k after reset release (k = 0, 1, ...) takes exactly eight clock cycles. Count rising edges from the first edge after release, starting at 0. The fetch address of instruction k appears on memAddr and is sampled by memory at edge 8k+1. The program counter then advances by one, modulo 4096.
- R3: The opcode is instruction bits 15..12 and the operand is bits 11..0.
- R4: Opcode 0 (stop) raises halted so that it is first seen high after edge 8k+5, whatever its operand. After that, memAddr holds, memWe stays 0, and halted stays 1 until reset.
- R5: Opcode 1 loads the general register with the operand, zero-extended to 16 bits.
- R6: Opcode 2 loads the pointer register with the operand.
- R7: Opcode 3 loads the general register with all 16 bits of memory word (pointer + operand) mod 4096.
- R8: Opcode 4 writes the general register to memory word (pointer + operand) mod 4096. memWe is high for exactly one cycle, with the write taking effect at edge 8k+6.
- R9: The effective address wraps modulo 4096. For example, pointer 0xF80 plus offset 0x0A0 gives 0x020.
- R10: Opcodes 5 through 15 change no register and cause no memory write.
- R11: The memory port is synchronous. Write data is taken at the edge where memWe is high. Read data for the address sampled at one edge must be valid on memRdata by the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halted | output | 1 | High once a stop instruction has executed |
| memAddr | output | 12 | Memory address, from the address register |
| memWdata | output | 16 | Memory write data, from the buffer register |
| memRdata | input | 16 | Memory read data, one cycle after the address |
| memWe | output | 1 | Memory write enable |

## Verification
The general and pointer registers have no port of their own. A wrong value in either one shows up only when a later store writes a wrong word or hits a wrong address. It can also show up when a later load fetches from the wrong place. That makes the delay between the fault and the symptom as long as the program distance to the next store. For this reason every random program is dense in stores, and the whole memory image is compared once the core halts. A fault in the phase counter or the program counter shows within one instruction frame. It appears as a shifted fetch address on memAddr, a store outside cycle 8k+6, or a halt seen at the wrong edge.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;

  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 16;
  localparam int OP_W      = 4;
  localparam int SUBCYCLES = 8;
  localparam int PHASE_W   = $clog2(SUBCYCLES);

  // Frame layout: phases 0..4 fetch/decode, 5..7 execute
  localparam logic [PHASE_W-1:0] PH_MAR_PC   = PHASE_W'(0);
  localparam logic [PHASE_W-1:0] PH_PC_INC   = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] PH_MBR_RD   = PHASE_W'(2);
  localparam logic [PHASE_W-1:0] PH_IR_LOAD  = PHASE_W'(3);
  localparam logic [PHASE_W-1:0] PH_EA_FORM  = PHASE_W'(4);
  localparam logic [PHASE_W-1:0] PH_EXEC_A   = PHASE_W'(5);
  localparam logic [PHASE_W-1:0] PH_EXEC_B   = PHASE_W'(6);
  localparam logic [PHASE_W-1:0] PH_EXEC_C   = PHASE_W'(7);

  localparam logic [OP_W-1:0] OPC_STOP    = 4'h0;
  localparam logic [OP_W-1:0] OPC_LDCONST = 4'h1;
  localparam logic [OP_W-1:0] OPC_LDPTR   = 4'h2;
  localparam logic [OP_W-1:0] OPC_LDREL   = 4'h3;
  localparam logic [OP_W-1:0] OPC_STREL   = 4'h4;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_PC,
    BUS_MBR,
    BUS_GREG,
    BUS_OPND
  } busSel_e;

  typedef struct packed {
    busSel_e busSel;
    logic    marFromBus;
    logic    marFromEa;
    logic    mbrFromMem;
    logic    mbrFromBus;
    logic    irFromBus;
    logic    gregFromBus;
    logic    spFromBus;
    logic    pcInc;
    logic    memWrite;
  } strobes_t;

endpackage

// File: rtl/seqcore_ctrl.sv
module seqcore_ctrl
  import seqcore_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] irOp,
  output strobes_t        strb,
  output logic            halted
);

  logic [PHASE_W-1:0] phase;
  logic               haltedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      haltedQ <= 1'b0;
    end else if (!haltedQ) begin
      phase <= (phase == PHASE_W'(SUBCYCLES - 1)) ? '0 : phase + 1'b1;
      if (phase == PH_EXEC_A && irOp == OPC_STOP) haltedQ <= 1'b1;
    end
  end

  always_comb begin
    strb        = '0;
    strb.busSel = BUS_IDLE;
    if (!haltedQ) begin
      unique case (phase)
        PH_MAR_PC: begin
          strb.busSel     = BUS_PC;
          strb.marFromBus = 1'b1;
        end
        PH_PC_INC:  strb.pcInc      = 1'b1;
        PH_MBR_RD:  strb.mbrFromMem = 1'b1;
        PH_IR_LOAD: begin
          strb.busSel    = BUS_MBR;
          strb.irFromBus = 1'b1;
        end
        PH_EA_FORM: strb.marFromEa = 1'b1;
        PH_EXEC_A: begin
          if (irOp == OPC_LDCONST) begin
            strb.busSel      = BUS_OPND;
            strb.gregFromBus = 1'b1;
          end else if (irOp == OPC_LDPTR) begin
            strb.busSel    = BUS_OPND;
            strb.spFromBus = 1'b1;
          end else if (irOp == OPC_STREL) begin
            strb.busSel     = BUS_GREG;
            strb.mbrFromBus = 1'b1;
          end
        end
        PH_EXEC_B: begin
          if (irOp == OPC_LDREL) strb.mbrFromMem = 1'b1;
          if (irOp == OPC_STREL) strb.memWrite   = 1'b1;
        end
        PH_EXEC_C: begin
          if (irOp == OPC_LDREL) begin
            strb.busSel      = BUS_MBR;
            strb.gregFromBus = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign halted = haltedQ;

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !haltedQ |=> (phase == $past(phase) + 1'b1) || haltedQ);

  // R4
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltedQ |=> haltedQ);

  // R4
  halt_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltedQ |-> phase == PH_EXEC_B);

endmodule

// File: rtl/seqcore_dpath.sv
module seqcore_dpath
  import seqcore_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strb,
  input  logic [DW-1:0]   memRdata,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  output logic [OP_W-1:0] irOp
);

  logic [AW-1:0] pc;
  logic [AW-1:0] mar;
  logic [AW-1:0] sp;
  logic [DW-1:0] mbr;
  logic [DW-1:0] ir;
  logic [DW-1:0] greg;
  logic [DW-1:0] bus;
  logic [AW-1:0] effAddr;

  always_comb begin
    unique case (strb.busSel)
      BUS_PC:   bus = DW'(pc);
      BUS_MBR:  bus = mbr;
      BUS_GREG: bus = greg;
      BUS_OPND: bus = DW'(ir[AW-1:0]);
      default:  bus = '0;
    endcase
  end

  assign effAddr = sp + ir[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc   <= '0;
      mar  <= '0;
      sp   <= '0;
      mbr  <= '0;
      ir   <= '0;
      greg <= '0;
    end else begin
      if (strb.pcInc)       pc   <= pc + 1'b1;
      if (strb.marFromBus)  mar  <= bus[AW-1:0];
      else if (strb.marFromEa) mar <= effAddr;
      if (strb.mbrFromMem)  mbr  <= memRdata;
      else if (strb.mbrFromBus) mbr <= bus;
      if (strb.irFromBus)   ir   <= bus;
      if (strb.gregFromBus) greg <= bus;
      if (strb.spFromBus)   sp   <= bus[AW-1:0];
    end
  end

  assign memAddr  = mar;
  assign memWdata = mbr;
  assign irOp     = ir[DW-1 -: OP_W];

endmodule

// File: rtl/seqcore_top.sv
module seqcore_top
  import seqcore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  output logic              halted,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe
);

  strobes_t        strb;
  logic [OP_W-1:0] irOp;

  seqcore_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .irOp   (irOp),
    .strb   (strb),
    .halted (halted)
  );

  seqcore_dpath #(.AW(ADDR_W), .DW(DATA_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .irOp     (irOp)
  );

  assign memWe = strb.memWrite;

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(memAddr) && !memWe && halted);

endmodule

// File: tb/seqcore_tb.sv
module seqcore_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXI       = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        halted;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        memWe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seqcore_top dut_i (
    .clk(clk), .rstN(rstN), .halted(halted), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memWe(memWe)
  );

  logic [15:0] dutMem [4096];
  logic [15:0] imgMem [4096];
  logic [15:0] refMem [4096];
  logic        loadReq = 1'b0;

  always @(posedge clk) begin
    if (loadReq) begin
      for (int a = 0; a < 4096; a++) dutMem[a] <= imgMem[a];
    end else begin
      if (memWe) dutMem[memAddr] <= memWdata;
      memRdata <= dutMem[memAddr];
    end
  end

  int cyc;
  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  int nTests = 0;
  int nFail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // expected trace from the bench model
  int          expN;
  int          expWCyc  [MAXI];
  logic [11:0] expWAddr [MAXI];
  logic [15:0] expWData [MAXI];
  logic [11:0] expPc    [MAXI];
  int          haltIdx;

  task automatic runModel();
    logic [11:0] pc, sp, opnd, ea;
    logic [15:0] g, ir;
    logic [3:0]  op;
    pc = '0; sp = '0; g = '0; expN = 0; haltIdx = -1;
    for (int k = 0; k < MAXI && haltIdx < 0; k++) begin
      expPc[k] = pc;
      ir   = refMem[pc];
      pc   = pc + 12'd1;
      op   = ir[15:12];
      opnd = ir[11:0];
      ea   = sp + opnd;
      case (op)
        4'h0: haltIdx = k;
        4'h1: g = {4'h0, opnd};
        4'h2: sp = opnd;
        4'h3: g = refMem[ea];
        4'h4: begin
          refMem[ea]     = g;
          expWCyc[expN]  = 8 * k + 6;
          expWAddr[expN] = ea;
          expWData[expN] = g;
          expN++;
        end
        default: ;
      endcase
    end
  endtask

  // negedge monitor
  bit   monOn = 1'b0;
  int   obsN;
  int   haltCyc;
  int   fetchErr;
  int   firstBadCyc;

  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (memWe) begin
        if (obsN < expN) begin
          chk(cyc == expWCyc[obsN], "R8", "store cycle", cyc, expWCyc[obsN]);
          chk(memAddr == expWAddr[obsN], "R9", "store address (R7 R8)",
              {20'h0, memAddr}, {20'h0, expWAddr[obsN]});
          chk(memWdata == expWData[obsN], "R5", "store data (R7 R10 R6)",
              {16'h0, memWdata}, {16'h0, expWData[obsN]});
        end else begin
          chk(1'b0, "R10", "unexpected store", obsN, expN);
        end
        obsN++;
      end
      if (halted && haltCyc < 0) haltCyc = cyc;
      if (haltCyc < 0 && (cyc % 8) == 1 && (cyc / 8) <= haltIdx && (cyc / 8) < MAXI) begin
        if (memAddr != expPc[cyc / 8]) begin
          fetchErr++;
          if (firstBadCyc < 0) firstBadCyc = cyc;
        end
      end
    end
  end

  task automatic runProg(input string name);
    logic [11:0] heldAddr;
    int          frozenErr;
    int          memErr;
    int          waitN;
    for (int a = 0; a < 4096; a++) refMem[a] = imgMem[a];
    runModel();
    monOn = 1'b0;
    @(negedge clk);
    rstN    = 1'b0;
    loadReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0;
    @(negedge clk);
    chk(halted == 1'b0 && memWe == 1'b0 && memAddr == 12'h000, "R1",
        {name, " reset state"}, {halted, memWe, 18'h0, memAddr}, 32'h0);
    obsN = 0; haltCyc = -1; fetchErr = 0; firstBadCyc = -1;
    monOn = 1'b1;
    rstN  = 1'b1;
    waitN = 0;
    while (haltCyc < 0 && waitN < 8 * MAXI + 40) begin
      @(negedge clk);
      waitN++;
    end
    chk(haltCyc == 8 * haltIdx + 6, "R4", {name, " halt cycle"}, haltCyc, 8 * haltIdx + 6);
    chk(obsN == expN, "R8", {name, " store count"}, obsN, expN);
    chk(fetchErr == 0, "R2", {name, " fetch addresses (R1 R3)"}, firstBadCyc, 32'hFFFFFFFF);
    heldAddr  = memAddr;
    frozenErr = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!halted || memWe || memAddr != heldAddr) frozenErr++;
    end
    chk(frozenErr == 0, "R4", {name, " frozen after halt"}, frozenErr, 0);
    memErr = 0;
    for (int a = 0; a < 4096; a++) if (dutMem[a] !== refMem[a]) memErr++;
    chk(memErr == 0, "R7", {name, " final memory image (R11)"}, memErr, 0);
    monOn = 1'b0;
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] opnd);
    return {op, opnd};
  endfunction

  task automatic clearImg();
    for (int a = 0; a < 4096; a++) imgMem[a] = 16'h0000;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nFail++;
    $display("FAIL R2 watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int          len;
    r = $urandom(32'd20240511);

    // R5 R9 R4: zero extension, wrapped store, stop with operand
    clearImg();
    imgMem[0] = ins(4'h2, 12'hFFF);
    imgMem[1] = ins(4'h1, 12'hFFF);
    imgMem[2] = ins(4'h4, 12'h010);
    imgMem[3] = ins(4'h0, 12'hFFF);
    runProg("zext_wrap");

    // R7 R9 R6: relative loads, plain and wrapped
    clearImg();
    imgMem[12'h800] = 16'hBEEF;
    imgMem[12'h020] = 16'h8001;
    imgMem[0] = ins(4'h2, 12'h7F0);
    imgMem[1] = ins(4'h3, 12'h010);
    imgMem[2] = ins(4'h4, 12'h011);
    imgMem[3] = ins(4'h2, 12'hF80);
    imgMem[4] = ins(4'h3, 12'h0A0);
    imgMem[5] = ins(4'h4, 12'h0A1);
    imgMem[6] = ins(4'h0, 12'h000);
    runProg("rel_load");

    // R10 R3: opcodes 5..15 do nothing
    clearImg();
    imgMem[0] = ins(4'h2, 12'h900);
    imgMem[1] = ins(4'h1, 12'h123);
    for (int i = 0; i < 11; i++) imgMem[2 + i] = ins(4'(5 + i), 12'hFFF);
    imgMem[13] = ins(4'h4, 12'h000);
    imgMem[14] = ins(4'h0, 12'h555);
    runProg("noop_ops");

    // R4 R1: stop as the very first word
    clearImg();
    imgMem[0] = ins(4'h0, 12'hABC);
    runProg("first_stop");

    // random programs
    for (int p = 0; p < 25; p++) begin
      for (int a = 0; a < 4096; a++) begin
        r = $urandom();
        imgMem[a] = (a >= 12'h800) ? r[15:0] : 16'h0000;
      end
      r = $urandom();
      len = 10 + int'(r[4:0]);
      imgMem[0] = ins(4'h2, {2'b10, r[14:5]});
      for (int i = 1; i < len; i++) begin
        r = $urandom();
        case (r[3:0])
          4'd0, 4'd1, 4'd2:        imgMem[i] = ins(4'h1, r[15:4]);
          4'd3, 4'd4:              imgMem[i] = ins(4'h2, {2'b10, r[13:4]});
          4'd5, 4'd6, 4'd7:        imgMem[i] = ins(4'h3, {2'b00, r[13:4]});
          4'd8, 4'd9, 4'd10:       imgMem[i] = ins(4'h4, {2'b00, r[13:4]});
          4'd11, 4'd12:            imgMem[i] = ins(4'(5 + (r[31:16] % 11)), r[15:4]);
          default:                 imgMem[i] = ins(4'h3, {2'b00, r[13:4]});
        endcase
      end
      r = $urandom();
      imgMem[len] = ins(4'h0, r[11:0] | 12'h001);
      runProg("random");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule